// File: doc/BRIEF.md
# Fair Hit Arbiter with Time-Word Merge

This block sits between eight per-channel hit buffers and a shared level-1 store. Each channel holds its request line high while it has a measurement waiting. The block serves the waiting channels one at a time and answers the served channel with a one-cycle acknowledge, so that its buffer can pop the entry. One cycle later it emits a write strobe with the channel number and a merged 20-bit time word. The upper 12 bits of that word count base-clock periods and the lower 8 bits give the position within the period.

Requests are taken in batches, so every waiting channel gets a turn before any channel is served twice. Within a batch the lowest channel number wins. The raw coarse counter and the 5-bit interpolator code are repacked according to the clock multiplication in use. A per-channel 9-bit correction is then added, and the coarse field wraps at a programmable roll-over value. In pair mode the block also forms a 7-bit pulse width from the leading and trailing times. The width is scaled by a programmable right shift and clamps at its maximum.

Top module: `hit_merge_arb`

## Requirements
- R1: A request enters the service batch only when the batch is empty; a request raised while a batch is open waits until every member of that batch has been acknowledged.
- R2: Within a batch, `ack_o` is one-hot or zero and picks the lowest-numbered member that is still requesting.
- R3: The time word is packed by `mode_i`. For 0 (or 3): `{cnt[11:0], fine, 3'b000}`. For 1: `{cnt[13:2], cnt[1:0], fine, 1'b0}`. For 2: `{cnt[14:3], cnt[2:0], fine}`. The upper 12 bits are coarse and the lower 8 bits are fine.
- R4: The channel's offset is added to the packed word before output. Offset bit 8 adds one coarse step and bits 7:0 add to the fine field, with a carry into the coarse field. A coarse result above `rollover_i` wraps to `result - (rollover_i + 1)`.
- R5: With `pair_i` high, `width_o` equals the trailing time minus the leading time, both packed per R3 and taken modulo `(rollover_i + 1) * 256`, shifted right by `wres_i`. With `pair_i` low, `width_o` is 0.
- R6: A shifted width above 127 is output as 7'h7F.
- R7: If two or more bits of `chsel_i` are high at a clock edge, `err_o` is set, and it stays set until reset.
- R8: After a channel is acknowledged, that channel is not acknowledged again for the next 3 cycles.
- R9: While `full_i` is high, no acknowledge and no write occur, and waiting requests stay pending and are served after `full_i` falls.
- R10: Reset clears `wr_o`, `err_o`, the open batch and the cooldowns. After reset, a fresh batch is formed from the current requests.
- R11: `wr_o` is high in the cycle after each acknowledge, carrying that channel's number, time word and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Per-channel request, held until acknowledged |
| full_i | input | 1 | Level-1 store cannot accept a write |
| chsel_i | input | 8 | Synchronised select lines echoed from the channel buffers |
| mode_i | input | 2 | Clock multiplication: 0 = x1, 1 = x4, 2 = x8 |
| pair_i | input | 1 | Leading/trailing pair measurement mode |
| wres_i | input | 3 | Width resolution right shift |
| rollover_i | input | 12 | Highest coarse value before wrap |
| lead_cnt_i | input | 120 | Per-channel 15-bit leading coarse counter |
| lead_fine_i | input | 40 | Per-channel 5-bit leading interpolator code |
| trl_cnt_i | input | 120 | Per-channel 15-bit trailing coarse counter |
| trl_fine_i | input | 40 | Per-channel 5-bit trailing interpolator code |
| ofs_i | input | 72 | Per-channel 9-bit offset |
| ack_o | output | 8 | One-cycle service acknowledge |
| wr_o | output | 1 | Write strobe to the level-1 store |
| ch_o | output | 3 | Channel number of the write |
| time_o | output | 20 | Merged, offset-corrected time word |
| width_o | output | 7 | Pulse width in pair mode |
| err_o | output | 1 | Sticky multiple-select error |

## Verification
A request sampled at one edge loads the batch. The acknowledge shows during the following cycle, and the write strobe with its data appears one edge after that. The error flag rises at the edge that samples the conflicting selects. The bench samples every output at the falling edge. It logs each write together with the cycle counter value and compares the log to the cycle in which it saw the acknowledge, so ordering, spacing and latency are checked from cycle stamps rather than fixed delays. Expected time words and widths are computed with integer modulo arithmetic in the bench, over every channel in every clock mode and across several width shifts.

// File: rtl/hmg_pkg.sv
package hmg_pkg;
  localparam int CNT_W  = 15;
  localparam int FINE_W = 5;
  localparam int CRS_W  = 12;
  localparam int SUB_W  = 8;
  localparam int TIME_W = CRS_W + SUB_W;
  localparam int OFS_W  = SUB_W + 1;
  localparam int WID_W  = 7;

  typedef enum logic [1:0] {
    CLK_X1  = 2'd0,
    CLK_X4  = 2'd1,
    CLK_X8  = 2'd2,
    CLK_RSV = 2'd3
  } clk_mode_e;

  // repack raw counter + interpolator into coarse/fine word
  function automatic logic [TIME_W-1:0] map_time(clk_mode_e m, logic [CNT_W-1:0] c,
                                                 logic [FINE_W-1:0] f);
    case (m)
      CLK_X4:  return {c[13:2], c[1:0], f, 1'b0};
      CLK_X8:  return {c[14:3], c[2:0], f};
      default: return {c[11:0], f, 3'b000};
    endcase
  endfunction
endpackage

// File: rtl/hmg_fair_q.sv
module hmg_fair_q #(
  parameter int NCH     = 8,
  parameter int SPACING = 4,
  localparam int CID_W  = $clog2(NCH),
  localparam int CL_W   = $clog2(SPACING) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic             full_i,
  output logic [NCH-1:0]   ack_o,
  output logic [CID_W-1:0] idx_o
);
  logic [NCH-1:0] q_q, busy, elig;

  for (genvar g = 0; g < NCH; g++) begin : g_cool
    logic [CL_W-1:0] cl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cl_q <= '0;
      else if (ack_o[g])      cl_q <= CL_W'(SPACING - 1);
      else if (cl_q != '0)    cl_q <= cl_q - 1'b1;
    end
    assign busy[g] = |cl_q;
  end

  assign elig = full_i ? '0 : (q_q & req_i & ~busy);

  // lowest index wins
  always_comb begin
    ack_o = '0;
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        ack_o    = '0;
        ack_o[i] = 1'b1;
        idx_o    = CID_W'(i);
      end
    end
  end

  // batch admission only when empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_q <= '0;
    else if (q_q == '0)   q_q <= req_i;
    else                  q_q <= q_q & req_i & ~ack_o;
  end
endmodule

// File: rtl/hmg_stamp.sv
module hmg_stamp
  import hmg_pkg::*;
(
  input  clk_mode_e          mode_i,
  input  logic               pair_i,
  input  logic [2:0]         wres_i,
  input  logic [CRS_W-1:0]   roll_i,
  input  logic [CNT_W-1:0]   lcnt_i,
  input  logic [FINE_W-1:0]  lfine_i,
  input  logic [CNT_W-1:0]   tcnt_i,
  input  logic [FINE_W-1:0]  tfine_i,
  input  logic [OFS_W-1:0]   ofs_i,
  output logic [TIME_W-1:0]  time_o,
  output logic [WID_W-1:0]   width_o
);
  logic [TIME_W-1:0] lead, trail;
  logic [SUB_W:0]    f_sum;
  logic [CRS_W:0]    c_sum, c_wrap, roll_p1, dc_raw, dc;
  logic [TIME_W:0]   tk_raw, tk, per, tk_sh;
  logic              unused_bits;

  assign lead    = map_time(mode_i, lcnt_i, lfine_i);
  assign trail   = map_time(mode_i, tcnt_i, tfine_i);
  assign roll_p1 = {1'b0, roll_i} + (CRS_W+1)'(1);

  // offset add, coarse wraps at roll-over
  assign f_sum  = {1'b0, lead[SUB_W-1:0]} + {1'b0, ofs_i[SUB_W-1:0]};
  assign c_sum  = {1'b0, lead[TIME_W-1:SUB_W]} + {{CRS_W{1'b0}}, ofs_i[SUB_W]}
                + {{CRS_W{1'b0}}, f_sum[SUB_W]};
  assign c_wrap = (c_sum > {1'b0, roll_i}) ? (c_sum - roll_p1) : c_sum;
  assign time_o = {c_wrap[CRS_W-1:0], f_sum[SUB_W-1:0]};

  // width modulo the roll-over period
  assign dc_raw = {1'b0, trail[TIME_W-1:SUB_W]} - {1'b0, lead[TIME_W-1:SUB_W]};
  assign dc     = dc_raw[CRS_W] ? (dc_raw + roll_p1) : dc_raw;
  assign tk_raw = {1'b0, dc[CRS_W-1:0], trail[SUB_W-1:0]}
                - {{(CRS_W+1){1'b0}}, lead[SUB_W-1:0]};
  assign per    = {roll_p1, {SUB_W{1'b0}}};
  assign tk     = tk_raw[TIME_W] ? (tk_raw + per) : tk_raw;
  assign tk_sh  = tk >> wres_i;

  always_comb begin
    if (!pair_i)                   width_o = '0;
    else if (|tk_sh[TIME_W:WID_W]) width_o = '1;
    else                           width_o = tk_sh[WID_W-1:0];
  end

  assign unused_bits = ^{c_wrap[CRS_W], dc[CRS_W]};
endmodule

// File: rtl/hit_merge_arb.sv
module hit_merge_arb
  import hmg_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int SPACING = 4,
  localparam int CID_W  = $clog2(NCH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        req_i,
  input  logic                  full_i,
  input  logic [NCH-1:0]        chsel_i,
  input  logic [1:0]            mode_i,
  input  logic                  pair_i,
  input  logic [2:0]            wres_i,
  input  logic [CRS_W-1:0]      rollover_i,
  input  logic [NCH*CNT_W-1:0]  lead_cnt_i,
  input  logic [NCH*FINE_W-1:0] lead_fine_i,
  input  logic [NCH*CNT_W-1:0]  trl_cnt_i,
  input  logic [NCH*FINE_W-1:0] trl_fine_i,
  input  logic [NCH*OFS_W-1:0]  ofs_i,
  output logic [NCH-1:0]        ack_o,
  output logic                  wr_o,
  output logic [CID_W-1:0]      ch_o,
  output logic [TIME_W-1:0]     time_o,
  output logic [WID_W-1:0]      width_o,
  output logic                  err_o
);
  logic [CID_W-1:0]  idx;
  logic [CNT_W-1:0]  s_lc, s_tc;
  logic [FINE_W-1:0] s_lf, s_tf;
  logic [OFS_W-1:0]  s_ofs;
  logic [TIME_W-1:0] m_time;
  logic [WID_W-1:0]  m_width;
  logic              multi_sel;

  hmg_fair_q #(.NCH(NCH), .SPACING(SPACING)) u_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .full_i (full_i),
    .ack_o  (ack_o),
    .idx_o  (idx)
  );

  assign s_lc  = lead_cnt_i [idx*CNT_W  +: CNT_W];
  assign s_lf  = lead_fine_i[idx*FINE_W +: FINE_W];
  assign s_tc  = trl_cnt_i  [idx*CNT_W  +: CNT_W];
  assign s_tf  = trl_fine_i [idx*FINE_W +: FINE_W];
  assign s_ofs = ofs_i      [idx*OFS_W  +: OFS_W];

  hmg_stamp u_stamp (
    .mode_i  (clk_mode_e'(mode_i)),
    .pair_i  (pair_i),
    .wres_i  (wres_i),
    .roll_i  (rollover_i),
    .lcnt_i  (s_lc),
    .lfine_i (s_lf),
    .tcnt_i  (s_tc),
    .tfine_i (s_tf),
    .ofs_i   (s_ofs),
    .time_o  (m_time),
    .width_o (m_width)
  );

  assign multi_sel = |(chsel_i & (chsel_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o    <= 1'b0;
      ch_o    <= '0;
      time_o  <= '0;
      width_o <= '0;
      err_o   <= 1'b0;
    end else begin
      wr_o  <= |ack_o;
      err_o <= err_o | multi_sel;
      if (|ack_o) begin
        ch_o    <= idx;
        time_o  <= m_time;
        width_o <= m_width;
      end
    end
  end
endmodule

// File: rtl/hmg_chk.sv
module hmg_chk #(
  parameter int NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] req_i,
  input logic           full_i,
  input logic [NCH-1:0] chsel_i,
  input logic [NCH-1:0] ack_o,
  input logic           wr_o,
  input logic           err_o
);
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o)); // R2
  AST_ACK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o & ~req_i) == '0); // R1
  AST_WR_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_o) |=> wr_o); // R11
  AST_NO_WR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ack_o) |=> !wr_o); // R11
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> (ack_o == '0)); // R9
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(chsel_i) > 1) |=> err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o & ($past(ack_o, 1) | $past(ack_o, 2) | $past(ack_o, 3))) == '0); // R8
endmodule

bind hit_merge_arb hmg_chk #(.NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .full_i  (full_i),
  .chsel_i (chsel_i),
  .ack_o   (ack_o),
  .wr_o    (wr_o),
  .err_o   (err_o)
);

// File: tb/sim_hit_merge_arb.sv
module sim_hit_merge_arb;
  localparam int NCH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  req, chsel;
  logic        full, pair;
  logic [1:0]  mode;
  logic [2:0]  wres;
  logic [11:0] ro;
  logic [14:0] lc [NCH];
  logic [4:0]  lf [NCH];
  logic [14:0] tc [NCH];
  logic [4:0]  tf [NCH];
  logic [8:0]  ofs[NCH];
  logic [NCH*15-1:0] lc_f, tc_f;
  logic [NCH*5-1:0]  lf_f, tf_f;
  logic [NCH*9-1:0]  ofs_f;

  for (genvar g = 0; g < NCH; g++) begin : g_pack
    assign lc_f [g*15 +: 15] = lc[g];
    assign tc_f [g*15 +: 15] = tc[g];
    assign lf_f [g*5  +: 5]  = lf[g];
    assign tf_f [g*5  +: 5]  = tf[g];
    assign ofs_f[g*9  +: 9]  = ofs[g];
  end

  logic [7:0]  ack;
  logic        wr, err;
  logic [2:0]  ch;
  logic [19:0] tim;
  logic [6:0]  wid;

  hit_merge_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .full_i(full), .chsel_i(chsel),
    .mode_i(mode), .pair_i(pair), .wres_i(wres), .rollover_i(ro),
    .lead_cnt_i(lc_f), .lead_fine_i(lf_f), .trl_cnt_i(tc_f), .trl_fine_i(tf_f),
    .ofs_i(ofs_f), .ack_o(ack), .wr_o(wr), .ch_o(ch), .time_o(tim),
    .width_o(wid), .err_o(err)
  );

  int checks = 0, errs = 0, cyc = 0, nlog = 0, ack_cyc = 0;
  int lg_ch[512], lg_t[512], lg_w[512], lg_c[512];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && wr) begin
      if (nlog < 512) begin
        lg_ch[nlog] = int'(ch);
        lg_t[nlog]  = int'(tim);
        lg_w[nlog]  = int'(wid);
        lg_c[nlog]  = cyc;
      end
      nlog = nlog + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errs + 1);
    $finish;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic int map_ticks(int m, int c, int f);
    if (m == 1)      return ((c >> 2) % 4096) * 256 + (c % 4) * 64 + f * 2;
    else if (m == 2) return ((c >> 3) % 4096) * 256 + (c % 8) * 32 + f;
    else             return (c % 4096) * 256 + f * 8;
  endfunction

  function automatic int exp_time(int m, int c, int f, int o, int r);
    int p = (r + 1) * 256;
    return (map_ticks(m, c, f) + (o / 256) * 256 + (o % 256)) % p;
  endfunction

  function automatic int exp_width(int m, int c1, int f1, int c2, int f2, int r, int w);
    int p = (r + 1) * 256;
    int d = ((map_ticks(m, c2, f2) - map_ticks(m, c1, f1)) % p + p) % p;
    d = d >> w;
    return (d > 127) ? 127 : d;
  endfunction

  // serve requests; clear each channel after its ack edge
  task automatic drive(input logic [7:0] start, input logic [7:0] late, input int late_at);
    int k = 0;
    logic [7:0] a;
    req = req | start;
    while ((req != 0 || k <= late_at) && k < 200) begin
      @(negedge clk);
      a = ack;
      if (a != 0) ack_cyc = cyc;
      @(posedge clk); #1;
      req = req & ~a;
      if (k == late_at) req = req | late;
      k++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic single(input int c, input string r);
    int base = nlog;
    drive(8'(1 << c), 8'h00, -1);
    chk({r, " count"}, nlog - base, 1);
    chk({r, " channel"}, lg_ch[base], c);
    chk({r, " time"}, lg_t[base],
        exp_time(int'(mode), int'(lc[c]), int'(lf[c]), int'(ofs[c]), int'(ro)));
    chk({r, " width"}, lg_w[base], pair ?
        exp_width(int'(mode), int'(lc[c]), int'(lf[c]), int'(tc[c]), int'(tf[c]),
                  int'(ro), int'(wres)) : 0);
    chk("R11 latency", lg_c[base], ack_cyc + 1);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; req = '0; chsel = '0; full = 1'b0; pair = 1'b0;
    mode = 2'd0; wres = 3'd0; ro = 12'd4095;
    for (int i = 0; i < NCH; i++) begin
      lc[i] = '0; lf[i] = '0; tc[i] = '0; tf[i] = '0; ofs[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset ack", int'(ack), 0);
    chk("R10 reset wr", int'(wr), 0);
    chk("R10 reset err", int'(err), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 / R4: every mode, every channel, offsets present
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int c = 0; c < NCH; c++) begin
        lc[c]  = 15'((c * 4099 + m * 777 + 12345) % 32768);
        lf[c]  = 5'((c * 7 + m * 3) % 32);
        ofs[c] = 9'((c * 37 + 5 + m * 101) % 512);
        single(c, "R3 R4 map");
      end
    end

    // R4 coarse wrap at roll-over, fine carry
    mode = 2'd0; ro = 12'd3563;
    lc[5] = 15'd3563; lf[5] = 5'd0; ofs[5] = 9'h100;
    single(5, "R4 wrap");
    chk("R4 wrap literal", lg_t[nlog-1], 0);
    lc[5] = 15'd10; lf[5] = 5'd31; ofs[5] = 9'h010;
    single(5, "R4 carry");
    chk("R4 carry literal", lg_t[nlog-1], 11 * 256 + 8);

    // R5 / R6 pair widths over shifts and channels
    pair = 1'b1; mode = 2'd2;
    for (int w = 0; w < 4; w++) begin
      wres = 3'(w);
      for (int c = 0; c < NCH; c++) begin
        lc[c]  = 15'((3500 + c * 9) * 8 + c);
        lf[c]  = 5'(c * 3);
        tc[c]  = 15'(((3500 + c * 9 + c * w + 1) % 3564) * 8 + (7 - c));
        tf[c]  = 5'((c * 5) % 32);
        ofs[c] = 9'(c * 11);
        single(c, "R5 R6 width");
      end
    end
    lc[1] = 15'(3563 * 8); lf[1] = 5'd0; tc[1] = 15'd9; tf[1] = 5'd0; wres = 3'd3;
    single(1, "R5 across wrap");
    chk("R5 literal", lg_w[nlog-1], 68);
    tc[1] = 15'(1000 * 8); wres = 3'd0;
    single(1, "R6 clamp");
    chk("R6 literal", lg_w[nlog-1], 127);
    pair = 1'b0; mode = 2'd0; ro = 12'd4095; wres = 3'd0;

    // R2 fixed priority, all channels at once
    base = nlog;
    drive(8'hFF, 8'h00, -1);
    chk("R2 count", nlog - base, 8);
    for (int i = 0; i < 8; i++) chk("R2 order", lg_ch[base+i], i);
    for (int i = 1; i < 8; i++) chk("R2 back-to-back", lg_c[base+i] - lg_c[base+i-1], 1);

    // R1 late request waits for batch to drain
    base = nlog;
    drive(8'h28, 8'h02, 0);
    chk("R1 count", nlog - base, 3);
    chk("R1 first", lg_ch[base], 3);
    chk("R1 second", lg_ch[base+1], 5);
    chk("R1 late last", lg_ch[base+2], 1);

    // R8 continuous request on one channel
    base = nlog;
    req = 8'h01;
    repeat (22) @(posedge clk);
    #1 req = 8'h00;
    repeat (4) @(posedge clk);
    #1;
    chk("R8 count", (nlog - base >= 5) ? 1 : 0, 1);
    for (int i = base + 1; i < nlog; i++) chk("R8 spacing", lg_c[i] - lg_c[i-1], 4);

    // R9 full blocks, request stays pending
    base = nlog;
    full = 1'b1;
    req = 8'h04;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 no ack while full", int'(ack), 0);
    end
    chk("R9 no write while full", nlog - base, 0);
    @(posedge clk); #1 full = 1'b0;
    drive(8'h00, 8'h00, -1);
    chk("R9 served after", nlog - base, 1);
    chk("R9 channel", lg_ch[base], 2);

    // R7 select error
    @(negedge clk) chsel = 8'h10;
    @(negedge clk) chsel = 8'h00;
    chk("R7 single select", int'(err), 0);
    @(negedge clk) chsel = 8'h05;
    @(negedge clk) chsel = 8'h00;
    chk("R7 set", int'(err), 1);
    repeat (5) @(negedge clk);
    chk("R7 sticky", int'(err), 1);

    // R10 reset mid-batch
    @(posedge clk); #1 req = 8'hFF;
    @(posedge clk);
    @(posedge clk); #1 req = 8'hFE; rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 wr in reset", int'(wr), 0);
    chk("R10 err cleared", int'(err), 0);
    @(posedge clk); #1;
    rst_n = 1'b1; req = 8'hFF;
    base = nlog;
    drive(8'h00, 8'h00, -1);
    chk("R10 fresh batch count", nlog - base, 8);
    chk("R10 fresh batch first", lg_ch[base], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule